// File: doc/BRIEF.md
# Stalled Bus Master Guard

This block watches the external bus masters that an arbiter can grant, and finds any master that takes its grant but never starts a transfer. For each monitored master, a counter runs while that master both requests and holds the grant and the bus stays idle, meaning no frame start is seen. If the master stays silent for a set number of clocks, the block latches a mask bit for it. The arbiter uses this bit to ignore that master's request from then on.

The mask is sticky. Only the single global guard control input changes it. Driving that input high switches detection off and clears every latched mask. Driving it low again re-arms detection. Setting the bit and then clearing it therefore cancels any earlier verdict. The processor's own request and the peripheral-bridge request are never wired to this block; only the monitored external masters appear on its ports.

Top module: `stall_master_guard`

## Requirements
- R1: While `rst` is sampled high at a clock edge, `mask_o` is all zeros after that edge.
- R2: Master i is "waiting" in a cycle when `req_i[i]` and `gnt_i[i]` are high, `frame_i` and `guard_off_i` are low, and `mask_o[i]` is low. When master i is waiting in IDLE_LIMIT (default 16) consecutive cycles, `mask_o[i]` goes high at the clock edge that ends the last of those cycles.
- R3: If `frame_i` is high in any cycle, the waiting run of every master restarts. IDLE_LIMIT-1 waiting cycles followed by a frame cycle do not set the mask.
- R4: A cycle in which `gnt_i[i]` is low restarts master i's waiting run.
- R5: A cycle in which `req_i[i]` is low restarts master i's waiting run.
- R6: Once `mask_o[i]` is high, it stays high whatever `req_i`, `gnt_i` and `frame_i` do, for as long as `guard_off_i` stays low.
- R7: When `guard_off_i` is sampled high, every `mask_o` bit is low after that edge. While it stays high, no mask bit is set, even if a waiting run would have reached its limit in that same cycle. After it returns low, runs start from zero.
- R8: Each master's counter and mask depend only on its own `req_i`/`gnt_i` bits, together with the shared `frame_i` and `guard_off_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | NUM_MON | Request, one bit per monitored master, high = requesting |
| gnt_i | input | NUM_MON | Grant, one bit per monitored master, high = granted |
| frame_i | input | 1 | High while a transaction start (frame) is asserted on the bus |
| guard_off_i | input | 1 | High disables detection and clears all masks |
| mask_o | output | NUM_MON | Registered per-master disable mask, high = request to be ignored |

## Verification
Two things can happen in the same cycle: a waiting run reaches its limit, and the guard control bit goes high. Directed cases drive a master through IDLE_LIMIT-1 waiting cycles and then raise `guard_off_i` exactly in the cycle that would have been the last one. The mask must stay low, and a fresh run after the control bit drops must again need the full IDLE_LIMIT cycles. A second collision puts both masters in the same cycle of expiry, and both mask bits must rise together. Random traffic with a low frame probability then mixes expiries, releases and control toggles. A bench model judges every cycle.

// File: rtl/smg_pkg.sv
package smg_pkg;

  parameter int unsigned SMG_DEF_NUM_MON = 2;
  parameter int unsigned SMG_DEF_LIMIT   = 16;

  // counter width able to hold 0 .. limit-1
  function automatic int unsigned cnt_width(input int unsigned limit);
    return (limit < 3) ? 1 : $clog2(limit);
  endfunction

endpackage

// File: rtl/smg_idle_timer.sv
module smg_idle_timer #(
  parameter int unsigned LIMIT = smg_pkg::SMG_DEF_LIMIT
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  output logic expire_o
);

  localparam int unsigned CW = smg_pkg::cnt_width(LIMIT);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_r;
  logic          at_last;

  assign at_last  = (cnt_r == LAST);
  assign expire_o = run_i && at_last;

  always_ff @(posedge clk) begin
    if (rst || !run_i || at_last) begin
      cnt_r <= '0;
    end else begin
      cnt_r <= cnt_r + 1'b1;
    end
  end

  // a break in the waiting run restarts the count (frame, grant or request)
  assert_run_break_R4: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> (cnt_r == '0));

  // each waiting cycle below the limit advances the count by one
  assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
    (run_i && !at_last) |=> (cnt_r == CW'($past(cnt_r) + 1'b1)));

endmodule

// File: rtl/smg_mask_latch.sv
module smg_mask_latch (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      q_o <= 1'b0;
    end else if (set_i) begin
      q_o <= 1'b1;
    end
  end

  assert_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && q_o) |=> q_o);

  assert_clear_wins_R7: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> !q_o);

  assert_set_needs_expiry_R2: assert property (@(posedge clk) disable iff (rst)
    (!q_o && !set_i) |=> !q_o);

endmodule

// File: rtl/stall_master_guard.sv
module stall_master_guard #(
  parameter int unsigned NUM_MON    = smg_pkg::SMG_DEF_NUM_MON,
  parameter int unsigned IDLE_LIMIT = smg_pkg::SMG_DEF_LIMIT
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_MON-1:0] req_i,
  input  logic [NUM_MON-1:0] gnt_i,
  input  logic               frame_i,
  input  logic               guard_off_i,
  output logic [NUM_MON-1:0] mask_o
);

  logic [NUM_MON-1:0] run;
  logic [NUM_MON-1:0] expire;

  for (genvar m = 0; m < NUM_MON; m++) begin : g_mon
    // waiting: requesting, granted, bus idle, detection armed, not yet masked
    assign run[m] = req_i[m] & gnt_i[m] & ~frame_i & ~guard_off_i & ~mask_o[m];

    smg_idle_timer #(.LIMIT(IDLE_LIMIT)) u_timer (
      .clk      (clk),
      .rst      (rst),
      .run_i    (run[m]),
      .expire_o (expire[m])
    );

    smg_mask_latch u_latch (
      .clk   (clk),
      .rst   (rst),
      .set_i (expire[m]),
      .clr_i (guard_off_i),
      .q_o   (mask_o[m])
    );

    // a master that is not granted can never gain a mask in that cycle
    assert_own_grant_R8: assert property (@(posedge clk) disable iff (rst)
      (!gnt_i[m] && !mask_o[m]) |=> !mask_o[m]);
  end

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (mask_o == '0));

  assert_off_blocks_R7: assert property (@(posedge clk) disable iff (rst)
    guard_off_i |=> (mask_o == '0));

endmodule

// File: tb/stall_master_guard_tb.sv
module stall_master_guard_tb;

  localparam int unsigned NM  = 2;
  localparam int unsigned LIM = 16;

  logic          clk = 1'b0;
  logic          rst;
  logic [NM-1:0] req, gnt, msk;
  logic          frame, off;

  int checks = 0;
  int fails  = 0;
  int        m_cnt  [NM];
  logic [NM-1:0] m_mask;

  always #2 clk = ~clk;

  stall_master_guard #(.NUM_MON(NM), .IDLE_LIMIT(LIM)) u_dut (
    .clk(clk), .rst(rst), .req_i(req), .gnt_i(gnt),
    .frame_i(frame), .guard_off_i(off), .mask_o(msk)
  );

  // expected mask bit after one edge, from the requirement text
  function automatic logic next_mask(input logic r, input logic g, input logic f,
                                     input logic o, input logic cur, input int c);
    if (o) return 1'b0;                               // R7
    if (cur) return 1'b1;                             // R6
    return (r && g && !f && (c == LIM - 1));          // R2
  endfunction

  function automatic int next_cnt(input logic r, input logic g, input logic f,
                                  input logic o, input logic cur, input int c);
    if (o || cur || !r || !g || f) return 0;          // R3 R4 R5 R7
    return (c == LIM - 1) ? 0 : c + 1;
  endfunction

  task automatic check(input string tag);
    checks++;
    if (msk !== m_mask) begin
      fails++;
      $display("FAIL %s: mask_o=%b expected=%b at %0t", tag, msk, m_mask, $time);
    end
  endtask

  task automatic cyc(input logic [NM-1:0] r, input logic [NM-1:0] g,
                     input logic f, input logic o, input string tag);
    req = r; gnt = g; frame = f; off = o;
    @(posedge clk);
    for (int i = 0; i < NM; i++) begin
      logic nm;
      nm = next_mask(r[i], g[i], f, o, m_mask[i], m_cnt[i]);
      m_cnt[i] = rst ? 0 : next_cnt(r[i], g[i], f, o, m_mask[i], m_cnt[i]);
      m_mask[i] = rst ? 1'b0 : nm;
    end
    @(negedge clk);
    check(tag);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    cyc('0, '0, 1'b0, 1'b0, "R1");
    cyc('1, '1, 1'b0, 1'b0, "R1");
    rst = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    rst = 1'b1; req = '0; gnt = '0; frame = 1'b0; off = 1'b0;
    m_mask = '0;
    for (int i = 0; i < NM; i++) m_cnt[i] = 0;
    @(negedge clk);
    do_reset();

    // R2: exactly LIM waiting cycles set master 0 only (R8)
    for (int k = 0; k < LIM - 1; k++) cyc(2'b01, 2'b01, 1'b0, 1'b0, "R2");
    checks++; if (msk !== 2'b00) begin fails++; $display("FAIL R2: early mask_o=%b expected=00", msk); end
    cyc(2'b01, 2'b01, 1'b0, 1'b0, "R2");
    checks++; if (msk !== 2'b01) begin fails++; $display("FAIL R2: mask_o=%b expected=01", msk); end

    // R6: sticky under any traffic
    for (int k = 0; k < 40; k++) cyc(2'($urandom), 2'($urandom), 1'($urandom), 1'b0, "R6");
    checks++; if (msk[0] !== 1'b1) begin fails++; $display("FAIL R6: mask_o[0]=%b expected=1", msk[0]); end

    // R7: off clears
    cyc('0, '0, 1'b0, 1'b1, "R7");
    checks++; if (msk !== 2'b00) begin fails++; $display("FAIL R7: mask_o=%b expected=00", msk); end
    cyc('0, '0, 1'b0, 1'b0, "R7");

    // R3: LIM-1 then frame, then LIM-1 again: no mask
    for (int k = 0; k < LIM - 1; k++) cyc(2'b10, 2'b10, 1'b0, 1'b0, "R3");
    cyc(2'b10, 2'b10, 1'b1, 1'b0, "R3");
    for (int k = 0; k < LIM - 1; k++) cyc(2'b10, 2'b10, 1'b0, 1'b0, "R3");
    checks++; if (msk !== 2'b00) begin fails++; $display("FAIL R3: mask_o=%b expected=00", msk); end
    cyc(2'b00, 2'b00, 1'b0, 1'b0, "R4");

    // R4: grant drop restarts
    for (int k = 0; k < LIM - 1; k++) cyc(2'b01, 2'b01, 1'b0, 1'b0, "R4");
    cyc(2'b01, 2'b00, 1'b0, 1'b0, "R4");
    for (int k = 0; k < LIM - 1; k++) cyc(2'b01, 2'b01, 1'b0, 1'b0, "R4");
    checks++; if (msk !== 2'b00) begin fails++; $display("FAIL R4: mask_o=%b expected=00", msk); end

    // R5: request drop restarts
    cyc(2'b00, 2'b01, 1'b0, 1'b0, "R5");
    for (int k = 0; k < LIM - 1; k++) cyc(2'b01, 2'b01, 1'b0, 1'b0, "R5");
    checks++; if (msk !== 2'b00) begin fails++; $display("FAIL R5: mask_o=%b expected=00", msk); end

    // R7 collision: off rises in the would-be expiry cycle
    cyc(2'b01, 2'b01, 1'b0, 1'b1, "R7");
    checks++; if (msk !== 2'b00) begin fails++; $display("FAIL R7: collision mask_o=%b expected=00", msk); end
    for (int k = 0; k < LIM - 1; k++) cyc(2'b01, 2'b01, 1'b0, 1'b0, "R7");
    checks++; if (msk !== 2'b00) begin fails++; $display("FAIL R7: rearm mask_o=%b expected=00", msk); end
    cyc(2'b01, 2'b01, 1'b0, 1'b0, "R7");
    checks++; if (msk !== 2'b01) begin fails++; $display("FAIL R7: rearm mask_o=%b expected=01", msk); end
    cyc('0, '0, 1'b0, 1'b1, "R7");

    // R8: both masters expire in the same cycle
    for (int k = 0; k < LIM; k++) cyc(2'b11, 2'b11, 1'b0, 1'b0, "R8");
    checks++; if (msk !== 2'b11) begin fails++; $display("FAIL R8: mask_o=%b expected=11", msk); end

    // random mix with rare frame and rare off
    for (int k = 0; k < 4000; k++) begin
      logic [NM-1:0] r, g;
      r = ($urandom_range(0, 9) < 8) ? 2'($urandom) | 2'b01 : 2'($urandom);
      g = ($urandom_range(0, 3) == 0) ? 2'($urandom) : (k[7] ? 2'b10 : 2'b01);
      cyc(r, g, ($urandom_range(0, 49) == 0), ($urandom_range(0, 199) == 0), "R2");
    end

    do_reset();
    checks++; if (msk !== 2'b00) begin fails++; $display("FAIL R1: mask_o=%b expected=00", msk); end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule